// File: doc/BRIEF.md
# I2C Master SCL Phase Timer

This block produces the clock-line timing for an I2C master. A 7-bit period setting T sets the length of a timer unit, 2·(1+T) system clocks. Each SCL period is ten units long. The first six units request SCL low and the last four request SCL high. A full period is therefore 20·(1+T) system clocks, and the duty cycle is fixed at 60 % low rather than an even split.

Besides the SCL level request, the block gives two single-cycle strobes. One marks the point in the low phase where the bit engine may drive a new SDA value. The other marks the point in the high phase where SDA is sampled. A restart pulse throws away the current period and begins a new low phase. Clock stretching and bit or byte sequencing belong to the logic around this block.

Top module: `scl_period_timer`

## Requirements
- R1: While reset is asserted, while `en_i` is 0, and from the cycle after `en_i` falls, `scl_high_o` is 1 and both strobes are 0. A `restart_i` pulse or a change of `period_i` while disabled has no effect on these outputs.
- R2: With T = max(`period_i`,1), one SCL period lasts exactly 20·(1+T) clock cycles and repeats without gaps.
- R3: Within a period, cycle offsets 0 to 12·(1+T)−1 have `scl_high_o`=0 and offsets 12·(1+T) to 20·(1+T)−1 have `scl_high_o`=1.
- R4: `sda_change_o` is 1 for exactly one cycle per period, at offset 6·(1+T), which is the middle of the low phase.
- R5: `sda_sample_o` is 1 for exactly one cycle per period, at offset 16·(1+T), which is the middle of the high phase.
- R6: A `period_i` value of 0 produces the same timing as a value of 1.
- R7: `period_i` is captured only when a period begins. A change in the middle of a period leaves that period's timing untouched, and the next period uses the new value.
- R8: The first cycle after the clock edge that sees `en_i` rise is offset 0 of a period (SCL low).
- R9: A `restart_i` pulse while enabled makes the next cycle offset 0 of a new period, and that period uses the `period_i` present with the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Timer enable |
| period_i | input | 7 | Timer period setting T (0 is treated as 1) |
| restart_i | input | 1 | Start a fresh period on the next cycle |
| scl_high_o | output | 1 | SCL level request: 1 = release high, 0 = drive low |
| sda_change_o | output | 1 | One-cycle strobe at the middle of the low phase |
| sda_sample_o | output | 1 | One-cycle strobe at the middle of the high phase |

## Verification
Every output is compared on every cycle against a position computed arithmetically over whole periods for T = 1, 9 and 127, and for T = 0. An off-by-one in the prescaler terminal count, in the unit wrap, or in the low/high boundary moves an edge or a strobe and is caught on the first affected cycle. A design that reloads the period value at any point other than a period boundary would stretch the period in which `period_i` changes. A design that ignores the value carried by a restart would keep the old unit length after the restart. Both cases are checked. Idle windows check that a design which kept counting, or which responded to restart while disabled, would show a low level or a stray strobe.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;

  // 0 is not a legal setting; it runs as the shortest legal period
  function automatic logic [6:0] clamp_period(input logic [6:0] p);
    return (p == 7'd0) ? 7'd1 : p;
  endfunction

endpackage

// File: rtl/scl_period_latch.sv
module scl_period_latch #(
  parameter int PERIOD_W = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic [PERIOD_W:0]   pre_max_o
);
  logic [PERIOD_W-1:0] tpr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tpr_q <= PERIOD_W'(1);
    else if (load_i) tpr_q <= (period_i == '0) ? PERIOD_W'(1) : period_i;
  end

  // unit length 2*(1+T) -> terminal count 2*T+1
  assign pre_max_o = {tpr_q, 1'b1};

  AST_TPR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpr_q != '0); // R6

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [PRE_W-1:0] pre_max_i,
  output logic             tick_o,
  output logic             pre_zero_o
);
  logic [PRE_W-1:0] pre_q;

  assign tick_o     = (pre_q == pre_max_i);
  assign pre_zero_o = (pre_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pre_q <= '0;
    else if (clear_i)  pre_q <= '0;
    else if (tick_o)   pre_q <= '0;
    else               pre_q <= pre_q + PRE_W'(1);
  end

  AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= pre_max_i); // R2

endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int TOTAL  = 10,
  parameter int UNIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              tick_i,
  output logic [UNIT_W-1:0] unit_o,
  output logic              period_end_o
);
  logic [UNIT_W-1:0] unit_q;

  assign unit_o       = unit_q;
  assign period_end_o = tick_i && (unit_q == UNIT_W'(TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           unit_q <= '0;
    else if (clear_i)      unit_q <= '0;
    else if (period_end_o) unit_q <= '0;
    else if (tick_i)       unit_q <= unit_q + UNIT_W'(1);
  end

  AST_UNIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_q < UNIT_W'(TOTAL)); // R3

endmodule

// File: rtl/scl_period_timer.sv
module scl_period_timer #(
  parameter int PERIOD_W   = 7,
  parameter int LOW_UNITS  = 6,
  parameter int HIGH_UNITS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                restart_i,
  output logic                scl_high_o,
  output logic                sda_change_o,
  output logic                sda_sample_o
);
  localparam int PRE_W    = PERIOD_W + 1;
  localparam int TOTAL    = LOW_UNITS + HIGH_UNITS;
  localparam int UNIT_W   = $clog2(TOTAL + 1);
  localparam int CHG_UNIT = LOW_UNITS / 2;
  localparam int SMP_UNIT = LOW_UNITS + HIGH_UNITS / 2;

  logic              active_q;
  logic              clear, load;
  logic              tick, pre_zero, period_end;
  logic [PRE_W-1:0]  pre_max;
  logic [UNIT_W-1:0] unit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= en_i;
  end

  // first enabled cycle and restart both start from offset 0
  assign clear = !en_i || !active_q || restart_i;
  assign load  = !active_q || restart_i || period_end;

  scl_period_latch #(.PERIOD_W(PERIOD_W)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .period_i  (period_i),
    .pre_max_o (pre_max)
  );

  scl_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .pre_max_i  (pre_max),
    .tick_o     (tick),
    .pre_zero_o (pre_zero)
  );

  scl_phase_ctr #(.TOTAL(TOTAL), .UNIT_W(UNIT_W)) u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear),
    .tick_i       (tick),
    .unit_o       (unit),
    .period_end_o (period_end)
  );

  assign scl_high_o   = !active_q || (unit >= UNIT_W'(LOW_UNITS));
  assign sda_change_o = active_q && pre_zero && (unit == UNIT_W'(CHG_UNIT));
  assign sda_sample_o = active_q && pre_zero && (unit == UNIT_W'(SMP_UNIT));

  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_high_o && !sda_change_o && !sda_sample_o)); // R1
  AST_CHANGE_IN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_change_o |-> !scl_high_o); // R4
  AST_SAMPLE_IN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_sample_o |-> scl_high_o); // R5
  AST_ENABLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !active_q) |=> !scl_high_o); // R8
  AST_RESTART_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && restart_i) |=> !scl_high_o); // R9

endmodule

// File: tb/scl_period_timer_bench.sv
`timescale 1ns/1ps
module scl_period_timer_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [6:0] period_i = 7'd1;
  logic       restart_i = 1'b0;
  logic       scl_high_o, sda_change_o, sda_sample_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scl_period_timer u_scl_period_timer (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .period_i(period_i),
    .restart_i(restart_i), .scl_high_o(scl_high_o),
    .sda_change_o(sda_change_o), .sda_sample_o(sda_sample_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // current negedge is offset k0 of a period with unit length u
  task automatic window(input int u, input int k0, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int k = (k0 + i) % (10 * u);
      bit eh = (k >= 6 * u);
      bit ec = (k == 3 * u);
      bit es = (k == 8 * u);
      chk(scl_high_o == eh, {tag, " R2 R3 scl level"}, scl_high_o, eh);
      chk(sda_change_o == ec, {tag, " R4 change strobe"}, sda_change_o, ec);
      chk(sda_sample_o == es, {tag, " R5 sample strobe"}, sda_sample_o, es);
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      chk(scl_high_o == 1'b1, {tag, " R1 scl idle"}, scl_high_o, 1);
      chk(sda_change_o == 1'b0, {tag, " R1 change idle"}, sda_change_o, 0);
      chk(sda_sample_o == 1'b0, {tag, " R1 sample idle"}, sda_sample_o, 0);
      @(negedge clk);
    end
  endtask

  task automatic start(input logic [6:0] p);
    period_i = p;
    en_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic stop();
    en_i = 1'b0;
    @(negedge clk);
    idle(5, "disable");
  endtask

  initial begin
    @(negedge clk);
    idle(3, "reset");
    rst_ni = 1'b1;
    @(negedge clk);
    idle(3, "post-reset");

    // R1: restart and period changes while disabled are ignored
    period_i = 7'd50; restart_i = 1'b1;
    @(negedge clk);
    restart_i = 1'b0;
    idle(4, "R1 restart while off");

    start(7'd1);   window(4,   0, 80,   "R8 T=1");   stop();
    start(7'd9);   window(20,  0, 400,  "R2 T=9");   stop();
    start(7'd127); window(256, 0, 5120, "R2 T=127"); stop();
    start(7'd0);   window(4,   0, 80,   "R6 T=0");   stop();

    // R7: change mid-period, takes effect at next boundary
    start(7'd1);
    window(4, 0, 10, "R7 before");
    period_i = 7'd9;
    window(4, 10, 30, "R7 old period");
    window(20, 0, 400, "R7 new period");
    stop();

    // R9: restart in mid low phase with a new value
    start(7'd1);
    window(4, 0, 17, "R9 before");
    period_i = 7'd9; restart_i = 1'b1;
    @(negedge clk);
    restart_i = 1'b0;
    window(20, 0, 200, "R9 after");
    // R9: restart during high phase with same value
    window(20, 200, 130, "R9 run");
    restart_i = 1'b1;
    @(negedge clk);
    restart_i = 1'b0;
    window(20, 0, 200, "R9 second");
    stop();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule